// File: doc/BRIEF.md
# Multiprocessor Interrupt Level Controller

This block collects thirty-two level-sensitive system interrupt lines, one timer line per processor and fifteen software interrupts per processor, and turns them into a 4-bit interrupt level for each of up to four CPUs. Each device line has a fixed level, and several lines can share one level. Each CPU's level is the highest of its active requests, and 0 when nothing is active.

Device lines are gated by a global mask word. The mask is changed through two write-one ports: one sets mask bits and the other clears them. Ordinary device requests go only to the CPU named in a target register. The four asynchronous error lines go to every CPU at level 15. Software interrupts are raised and dropped through per-CPU write-one set and clear ports. A simple word-addressed register port gives read and write access. Reads return data combinationally, and writes take effect at the clock edge.

Top module: `irqmc_top`

## Requirements
- R1: After reset the mask word reads 0xFFFFFFFF, the target reads 0, no software interrupt is pending, and every CPU level is 0. With everything masked, a device request leaves all levels at 0.
- R2: A write to word address 3 sets the mask bits written as 1, and a write to address 2 clears them. Bits written as 0 keep their value. Address 1 reads the mask word.
- R3: Address 0 reads the device lines as sampled on the previous clock edge, whether or not they are masked.
- R4: The device bit levels are as follows. VME levels 1 to 7 are on bits 0–6 and the SBus-style levels 1 to 7 are on bits 7–13; both map, in order, to levels 2, 3, 5, 7, 9, 11 and 13. Bits 14 and 15 map to 12, bit 16 to 6, bit 17 to 13, bit 18 to 4, bit 19 to 10, bit 20 to 8, bit 21 to 9 and bit 22 to 11. Bits 23–26 and bit 31 produce no level.
- R5: An unmasked non-error device request reaches only the CPU whose number is written in the low 2 bits of address 4.
- R6: An unmasked error line (bits 27–30) drives level 15 on every CPU.
- R7: Mask bit 31 blocks every device line and every CPU timer. It does not block software interrupts.
- R8: For CPU c, writing bit 16+N (N = 1..15) to address 16+4c+2 raises software interrupt N, and writing it to 16+4c+1 drops it. Address 16+4c reads the pending soft bits at 17–31. A pending soft interrupt N gives that CPU level N.
- R9: The timer input of CPU c shows at bit 7 of that CPU's pending word. It gives level 14 to CPU c only, and global mask bit 7 gates it.
- R10: Each CPU's level is the maximum over its active requests, and 0 when none is active.
- R11: A level follows a change on a device line at the second rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| devIrq | input | 32 | Level-sensitive device interrupt lines |
| cpuTick | input | NUM_CPU | Per-CPU timer interrupt lines |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| cpuLevel | output | 4*NUM_CPU | Interrupt level per CPU, CPU 0 in the low nibble |

## Verification
The bench builds the block with NUM_CPU = 4, the full count. This lets it sweep every one of the 32 device bits against every target value and compare each CPU's level to an arithmetic form of the level map. It also steps through all fifteen software levels on each CPU and each CPU's timer. Priority overlaps between software, timer, device and error requests are exercised, as are the two-edge input latency and the master mask.

// File: rtl/irqmc_pkg.sv
package irqmc_pkg;
  localparam int SRC_W     = 32;
  localparam int LVL_W     = 4;
  localparam int MAX_CPU   = 4;
  localparam int CPU_IDX_W = $clog2(MAX_CPU);
  localparam int ADDR_W    = 5;
  localparam int SOFT_N    = 15;
  localparam int SOFT_BASE = 16;
  localparam int MASK_ALL  = 31;
  localparam int ERR_LO    = 27;
  localparam int ERR_HI    = 30;
  localparam int TICK_BIT  = 7;
  localparam logic [LVL_W-1:0] TICK_LVL = 4'd14;
  localparam logic [LVL_W-1:0] ERR_LVL  = 4'd15;

  localparam logic [ADDR_W-1:0] A_GPEND = 5'd0;
  localparam logic [ADDR_W-1:0] A_MASK  = 5'd1;
  localparam logic [ADDR_W-1:0] A_MCLR  = 5'd2;
  localparam logic [ADDR_W-1:0] A_MSET  = 5'd3;
  localparam logic [ADDR_W-1:0] A_TGT   = 5'd4;

  typedef enum logic [2:0] {RD_NONE, RD_GPEND, RD_MASK, RD_TGT, RD_CPEND} rd_sel_e;

  typedef struct packed {
    logic                 maskSet;
    logic                 maskClr;
    logic                 tgtWr;
    logic [MAX_CPU-1:0]   softSet;
    logic [MAX_CPU-1:0]   softClr;
    rd_sel_e              rdSel;
    logic [CPU_IDX_W-1:0] rdCpu;
  } strobe_t;

  // fixed device-bit to level table
  function automatic logic [LVL_W-1:0] srcLevel(input int b);
    case (b)
      0, 7:           return 4'd2;
      1, 8:           return 4'd3;
      2, 9:           return 4'd5;
      3, 10:          return 4'd7;
      4, 11:          return 4'd9;
      5, 12:          return 4'd11;
      6, 13:          return 4'd13;
      14, 15:         return 4'd12;
      16:             return 4'd6;
      17:             return 4'd13;
      18:             return 4'd4;
      19:             return 4'd10;
      20:             return 4'd8;
      21:             return 4'd9;
      22:             return 4'd11;
      27, 28, 29, 30: return 4'd15;
      default:        return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/irqmc_ctrl.sv
module irqmc_ctrl
  import irqmc_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           st
);
  logic [CPU_IDX_W-1:0] slotCpu;
  logic [1:0]           slotReg;

  assign slotCpu = regAddr[2 +: CPU_IDX_W];
  assign slotReg = regAddr[1:0];

  always_comb begin
    st       = '0;
    st.rdSel = RD_NONE;
    if (regAddr[ADDR_W-1]) begin
      if (int'(slotCpu) < NUM_CPU) begin
        case (slotReg)
          2'd0:    st.rdSel = RD_CPEND;
          2'd1:    st.softClr[slotCpu] = regWe;
          2'd2:    st.softSet[slotCpu] = regWe;
          default: st.rdSel = RD_NONE;
        endcase
        st.rdCpu = slotCpu;
      end
    end else begin
      case (regAddr)
        A_GPEND: st.rdSel   = RD_GPEND;
        A_MASK:  st.rdSel   = RD_MASK;
        A_MCLR:  st.maskClr = regWe;
        A_MSET:  st.maskSet = regWe;
        A_TGT: begin
          st.rdSel = RD_TGT;
          st.tgtWr = regWe;
        end
        default: st.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/irqmc_datapath.sv
module irqmc_datapath
  import irqmc_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [SRC_W-1:0]         devIrq,
  input  logic [NUM_CPU-1:0]       cpuTick,
  input  logic [SRC_W-1:0]         regWdata,
  input  strobe_t                  st,
  output logic [SRC_W-1:0]         regRdata,
  output logic [NUM_CPU*LVL_W-1:0] cpuLevel,
  output logic [SRC_W-1:0]         maskQ,
  output logic [CPU_IDX_W-1:0]     tgtQ,
  output logic [SRC_W-1:0]         srcQ
);
  logic [NUM_CPU-1:0]   tickQ;
  logic [SOFT_N-1:0]    softQ  [NUM_CPU];
  logic [LVL_W-1:0]     levelQ [NUM_CPU];
  logic [LVL_W-1:0]     lvlNext[NUM_CPU];
  logic [LVL_W-1:0]     devLvl;
  logic                 errAny;
  logic                 gateOpen;
  logic                 tickOpen;
  logic [SOFT_N-1:0]    wSoft;

  assign wSoft    = regWdata[SOFT_BASE+1 +: SOFT_N];
  assign gateOpen = ~maskQ[MASK_ALL];
  assign tickOpen = gateOpen & ~maskQ[TICK_BIT];
  assign errAny   = gateOpen & (|(srcQ[ERR_HI:ERR_LO] & ~maskQ[ERR_HI:ERR_LO]));

  // sampling and mask / target state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ  <= '0;
      tickQ <= '0;
      maskQ <= '1;
      tgtQ  <= '0;
    end else begin
      srcQ  <= devIrq;
      tickQ <= cpuTick;
      if (st.maskSet) maskQ <= maskQ | regWdata;
      else if (st.maskClr) maskQ <= maskQ & ~regWdata;
      if (st.tgtWr) tgtQ <= regWdata[CPU_IDX_W-1:0];
    end
  end

  // per-cpu software interrupt state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CPU; c++) softQ[c] <= '0;
    end else begin
      for (int c = 0; c < NUM_CPU; c++) begin
        if (st.softSet[c]) softQ[c] <= softQ[c] | wSoft;
        else if (st.softClr[c]) softQ[c] <= softQ[c] & ~wSoft;
      end
    end
  end

  // highest targeted device level (errors handled as broadcast)
  always_comb begin
    devLvl = '0;
    for (int b = 0; b < SRC_W; b++) begin
      if (srcQ[b] && !maskQ[b] && gateOpen && !(b >= ERR_LO && b <= ERR_HI)
          && srcLevel(b) > devLvl)
        devLvl = srcLevel(b);
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) begin
      lvlNext[c] = '0;
      for (int n = 1; n <= SOFT_N; n++)
        if (softQ[c][n-1]) lvlNext[c] = LVL_W'(n);
      if (tgtQ == CPU_IDX_W'(c) && devLvl > lvlNext[c]) lvlNext[c] = devLvl;
      if (tickQ[c] && tickOpen && TICK_LVL > lvlNext[c]) lvlNext[c] = TICK_LVL;
      if (errAny) lvlNext[c] = ERR_LVL;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CPU; c++) levelQ[c] <= '0;
    end else begin
      for (int c = 0; c < NUM_CPU; c++) levelQ[c] <= lvlNext[c];
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_out
    assign cpuLevel[c*LVL_W +: LVL_W] = levelQ[c];
  end

  always_comb begin
    regRdata = '0;
    case (st.rdSel)
      RD_GPEND: regRdata = srcQ;
      RD_MASK:  regRdata = maskQ;
      RD_TGT:   regRdata[CPU_IDX_W-1:0] = tgtQ;
      RD_CPEND: begin
        regRdata[SOFT_BASE+1 +: SOFT_N] = softQ[st.rdCpu];
        regRdata[TICK_BIT]              = tickQ[st.rdCpu];
      end
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/irqmc_top.sv
module irqmc_top
  import irqmc_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [SRC_W-1:0]         devIrq,
  input  logic [NUM_CPU-1:0]       cpuTick,
  input  logic                     regWe,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [SRC_W-1:0]         regWdata,
  output logic [SRC_W-1:0]         regRdata,
  output logic [NUM_CPU*LVL_W-1:0] cpuLevel
);
  strobe_t              st;
  logic [SRC_W-1:0]     maskQ;
  logic [CPU_IDX_W-1:0] tgtQ;
  logic [SRC_W-1:0]     srcQ;

  irqmc_ctrl #(.NUM_CPU(NUM_CPU)) u_ctrl (
    .regWe   (regWe),
    .regAddr (regAddr),
    .st      (st)
  );

  irqmc_datapath #(.NUM_CPU(NUM_CPU)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .devIrq   (devIrq),
    .cpuTick  (cpuTick),
    .regWdata (regWdata),
    .st       (st),
    .regRdata (regRdata),
    .cpuLevel (cpuLevel),
    .maskQ    (maskQ),
    .tgtQ     (tgtQ),
    .srcQ     (srcQ)
  );
endmodule

// File: rtl/irqmc_checker.sv
module irqmc_checker
  import irqmc_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [SRC_W-1:0]         devIrq,
  input logic                     regWe,
  input logic [ADDR_W-1:0]        regAddr,
  input logic [SRC_W-1:0]         regWdata,
  input logic [NUM_CPU*LVL_W-1:0] cpuLevel,
  input logic [SRC_W-1:0]         maskQ,
  input logic [CPU_IDX_W-1:0]     tgtQ,
  input logic [SRC_W-1:0]         srcQ
);
  logic errNow;
  logic maskWr;
  assign errNow = !maskQ[MASK_ALL] && (|(srcQ[ERR_HI:ERR_LO] & ~maskQ[ERR_HI:ERR_LO]));
  assign maskWr = regWe && (regAddr == A_MSET || regAddr == A_MCLR);

  p_mask_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_MSET) |=> ((maskQ & $past(regWdata)) == $past(regWdata)));

  p_mask_clr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_MCLR) |=> ((maskQ & $past(regWdata)) == '0));

  p_mask_keep_r2: assert property (@(posedge clk) disable iff (!rstN)
    !maskWr |=> $stable(maskQ));

  p_src_sample_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (srcQ == $past(devIrq)));

  p_tgt_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regAddr == A_TGT) |=> $stable(tgtQ));

  p_err_bcast_r6: assert property (@(posedge clk) disable iff (!rstN)
    errNow |=> (cpuLevel == '1));
endmodule

bind irqmc_top irqmc_checker #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .devIrq   (devIrq),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .cpuLevel (cpuLevel),
  .maskQ    (maskQ),
  .tgtQ     (tgtQ),
  .srcQ     (srcQ)
);

// File: tb/tb_irqmc_top.sv
module tb_irqmc_top;
  localparam int NC = 4;
  logic        clk = 0;
  logic        rstN = 0;
  logic [31:0] devIrq = '0;
  logic [NC-1:0] cpuTick = '0;
  logic        regWe = 0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [NC*4-1:0] cpuLevel;
  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;

  irqmc_top #(.NUM_CPU(NC)) dut (
    .clk(clk), .rstN(rstN), .devIrq(devIrq), .cpuTick(cpuTick),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .cpuLevel(cpuLevel)
  );

  always #10 clk = ~clk;

  function automatic int expLevel(input int b);
    int k;
    if (b <= 13) begin
      k = (b % 7) + 1;
      return (k <= 2) ? k + 1 : 2 * k - 1;
    end
    if (b == 14 || b == 15) return 12;
    if (b >= 27 && b <= 30) return 15;
    case (b)
      16: return 6;
      17: return 13;
      18: return 4;
      19: return 10;
      20: return 8;
      21: return 9;
      22: return 11;
      default: return 0;
    endcase
  endfunction

  function automatic int lvl(input int c);
    return int'(cpuLevel[c*4 +: 4]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1; regAddr = 5'(a); regWdata = d;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    regAddr = 5'(a);
    #1 d = regRdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rd(1, d); chk("R1 mask", int'(d), 32'hFFFF_FFFF);
    rd(4, d); chk("R1 target", int'(d), 0);
    for (int c = 0; c < NC; c++) begin
      rd(16 + 4*c, d); chk("R1 soft pend", int'(d), 0);
      chk("R1 level", lvl(c), 0);
    end
    devIrq = 32'h0004_0000;
    settle();
    for (int c = 0; c < NC; c++) chk("R1 masked level", lvl(c), 0);
    devIrq = '0;

    // R2 write-one set/clear
    wr(2, 32'hFFFF_FFFF);
    rd(1, d); chk("R2 clear all", int'(d), 0);
    wr(3, 32'h0000_00F0);
    rd(1, d); chk("R2 set", int'(d), 32'hF0);
    wr(2, 32'h0000_0030);
    rd(1, d); chk("R2 clear", int'(d), 32'hC0);
    wr(3, 32'h0);
    rd(1, d); chk("R2 set zero", int'(d), 32'hC0);
    wr(2, 32'h0);
    rd(1, d); chk("R2 clear zero", int'(d), 32'hC0);
    devIrq = 32'h80;
    settle();
    chk("R2 masked bit", lvl(0), 0);
    rd(0, d); chk("R3 pend ignores mask", int'(d), 32'h80);
    devIrq = 32'h08;
    settle();
    chk("R2 unmasked bit", lvl(0), 7);
    wr(2, 32'hFFFF_FFFF);
    devIrq = '0;
    settle();

    // R11 latency
    @(negedge clk);
    devIrq = 32'h0004_0000;
    @(posedge clk); @(negedge clk);
    chk("R11 one edge", lvl(0), 0);
    @(posedge clk); @(negedge clk);
    chk("R11 two edges", lvl(0), 4);
    devIrq = '0;
    settle();

    // R3 R4 R5 R6 sweep
    for (int t = 0; t < NC; t++) begin
      wr(4, 32'(t));
      rd(4, d); chk("R5 target readback", int'(d), t);
      for (int b = 0; b < 32; b++) begin
        devIrq = 32'h1 << b;
        settle();
        if (t == 0) begin
          rd(0, d); chk("R3 pending", int'(d), int'(32'h1 << b));
        end
        for (int c = 0; c < NC; c++) begin
          int e;
          e = ((b >= 27 && b <= 30) || c == t) ? expLevel(b) : 0;
          if (b >= 27 && b <= 30) chk("R6 error broadcast", lvl(c), e);
          else if (c == t) chk("R4 level map", lvl(c), e);
          else chk("R5 non-target", lvl(c), e);
        end
      end
    end
    devIrq = '0;
    wr(4, 0);
    settle();

    // R8 software interrupts
    for (int c = 0; c < NC; c++) begin
      for (int n = 1; n <= 15; n++) begin
        wr(16 + 4*c + 2, 32'h1 << (16 + n));
        settle();
        chk("R8 soft level", lvl(c), n);
        chk("R8 other cpu", lvl((c + 1) % NC), 0);
        rd(16 + 4*c, d); chk("R8 soft pend", int'(d), int'(32'h1 << (16 + n)));
        wr(16 + 4*c + 1, 32'h1 << (16 + n));
        settle();
        chk("R8 soft cleared", lvl(c), 0);
      end
    end
    wr(18, (32'h1 << 19) | (32'h1 << 25));
    wr(17, 32'h1 << 25);
    settle();
    chk("R8 partial clear", lvl(0), 3);
    wr(17, 32'hFFFE_0000);
    settle();

    // R9 per-cpu timer
    for (int c = 0; c < NC; c++) begin
      cpuTick = NC'(1) << c;
      settle();
      for (int k = 0; k < NC; k++) chk("R9 timer level", lvl(k), (k == c) ? 14 : 0);
      rd(16 + 4*c, d); chk("R9 timer pend", int'(d), 32'h80);
      wr(3, 32'h80);
      settle();
      chk("R9 timer gated", lvl(c), 0);
      rd(16 + 4*c, d); chk("R9 pend while gated", int'(d), 32'h80);
      wr(2, 32'h80);
    end
    cpuTick = '0;

    // R10 maximum selection
    wr(4, 2);
    wr(16 + 8 + 2, 32'h1 << 19);
    devIrq = 32'h8000;
    settle();
    chk("R10 device over soft", lvl(2), 12);
    chk("R10 idle cpu", lvl(1), 0);
    cpuTick = 4'b0100;
    settle();
    chk("R10 timer over device", lvl(2), 14);
    wr(16 + 8 + 2, 32'h8000_0000);
    settle();
    chk("R10 soft15 over timer", lvl(2), 15);
    wr(16 + 8 + 1, 32'hFFFE_0000);
    cpuTick = '0;
    devIrq = '0;
    settle();
    chk("R10 none active", lvl(2), 0);

    // R7 master mask
    devIrq = (32'h1 << 28) | (32'h1 << 18);
    cpuTick = '1;
    wr(3, 32'h8000_0000);
    settle();
    for (int c = 0; c < NC; c++) chk("R7 mask all", lvl(c), 0);
    wr(16 + 4 + 2, 32'h1 << 21);
    settle();
    chk("R7 soft passes", lvl(1), 5);
    wr(2, 32'h8000_0000);
    settle();
    for (int c = 0; c < NC; c++) chk("R6 error after unmask", lvl(c), 15);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule